// File: doc/BRIEF.md
# Pipelined Bus Next-Address Sequencer

This block sits on the processor side of an external memory bus. It issues the address strobe for each bus cycle and tracks the cycle that is in flight. It also decides whether an early "next address" indication from the memory system may start the address phase of the following cycle before the current one has finished its data transfers. At most one such early cycle can be queued behind the current one. The early strobe always appears a fixed two clocks after the indication is taken.

Internal bus requests arrive on a valid/ready port. Each request carries a cycle type, a lock flag and a beat count. `req_ready` is combinational and may depend on `req_valid`. A request transfers on a rising edge where both are high. The requester holds `req_valid` and the request fields steady until that transfer happens. A request transfers in one of two ways. The first is as an ordinary cycle while the bus is idle and no hold is active. The second is as a pipelined cycle in the clock where a qualified next-address indication is taken. The cacheable and write-back attribute inputs are latched once per cycle, on the first clock that brings either a qualified next-address indication or a data-ready.

Cycle types on `req_kind`: 0 memory read, 1 write-through memory write, 2 writeback, 3 I/O read, 4 I/O write, 5 special cycle, 6 interrupt acknowledge. All inputs are sampled on the rising clock edge.

Top module: `pbus_na_seq`

## Requirements
- R1: While `rst` is high, `req_ready` is 0. After a clock with `rst` high, `ads`, `cyc_busy` and `attr_valid` are 0, and any cycle in flight is dropped.
- R2: When the bus is idle and none of `backoff`, `hold_ack`, `addr_hold`, `init` or `quiesce` is high, a valid request is accepted at once. `ads` is high for exactly the one clock after acceptance. Any of those five inputs holds the request off.
- R3: The next-address input counts only from the second clock after the strobe edge, up to and including the clock of the first data-ready of that cycle. It does not count in the clock right after the strobe, or after the first data-ready.
- R4: When a next-address indication is taken, the pending request is accepted in that clock. `ads` for it is high in the clock that starts two edges later.
- R5: The next-address input counts only while the current cycle is a memory read (0) or a write-through write (1). Types 2 to 6 make it ignored.
- R6: A current cycle marked locked makes the next-address input ignored, whatever its type.
- R7: The next-address input is ignored in any clock where `backoff`, `hold_ack`, `init`, `probe_rdy` or `quiesce` is high.
- R8: While `addr_hold` is high, the next-address input counts only if the current cycle's strobe was sampled while `addr_hold` was low. If the strobe was sampled with `addr_hold` high, the input is ignored until `addr_hold` falls.
- R9: A taken indication needs a valid pending request. A pending request that is locked or is a writeback (2) is never issued as a pipelined cycle. Other types, including I/O, may be.
- R10: Only one pipelined cycle may wait behind the current one. Further indications are ignored until the current cycle ends. An indication in the clock of the current cycle's final data-ready is ignored.
- R11: `attr_cacheable` and `attr_wb` take `cache_en_in` and `wb_mode_in` on the first clock of a cycle with a counted next-address indication or a data-ready. `attr_valid` then rises, and the values hold until the next cycle starts.
- R12: A cycle ends after `req_beats`+1 data-ready clocks. A waiting pipelined cycle then becomes current, and its own beats are counted. With none waiting, `cyc_busy` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Internal request present |
| req_ready | output | 1 | Request transfers this edge |
| req_kind | input | 3 | Request cycle type |
| req_lock | input | 1 | Request is a locked cycle |
| req_beats | input | BEAT_W | Data-ready clocks minus one |
| nxt_addr | input | 1 | External next-address indication |
| data_rdy | input | 1 | External data-ready for one beat |
| backoff | input | 1 | Bus back-off |
| hold_ack | input | 1 | Bus hold acknowledged |
| addr_hold | input | 1 | Address hold request |
| init | input | 1 | Initialisation request |
| probe_rdy | input | 1 | Debug probe mode active |
| quiesce | input | 1 | Halt, shutdown or clock-stop state |
| cache_en_in | input | 1 | Cacheability attribute from memory |
| wb_mode_in | input | 1 | Write-policy attribute from memory |
| ads | output | 1 | Address strobe |
| cyc_busy | output | 1 | A bus cycle is current |
| attr_valid | output | 1 | Attributes latched for current cycle |
| attr_cacheable | output | 1 | Latched cacheability |
| attr_wb | output | 1 | Latched write policy |

## Verification
The assertions assume that the memory side keeps to bus order. No data-ready arrives for a cycle before the clock after its strobe has been sampled. Data-ready is low whenever no cycle is current. The stimulus keeps to this by raising `data_rdy` only after it has seen `ads` fall back low. It also waits for a pipelined strobe before draining the beats of that cycle. Holds are raised only around next-address or acceptance clocks, never against a strobe still in the delay line.

// File: rtl/pbus_pkg.sv
package pbus_pkg;

  typedef enum logic [2:0] {
    CK_MEM_RD  = 3'd0,
    CK_MEM_WT  = 3'd1,
    CK_MEM_WB  = 3'd2,
    CK_IO_RD   = 3'd3,
    CK_IO_WR   = 3'd4,
    CK_SPECIAL = 3'd5,
    CK_INTA    = 3'd6
  } cyc_kind_e;

  // Current cycle types that allow an early next address.
  function automatic logic na_kind_ok(input logic [2:0] k, input logic lk);
    return !lk && (k == CK_MEM_RD || k == CK_MEM_WT);
  endfunction

  // Pending request types that may be issued as a pipelined cycle.
  function automatic logic pipe_kind_ok(input logic [2:0] k, input logic lk);
    return !lk && (k != CK_MEM_WB);
  endfunction

endpackage

// File: rtl/pbus_ads_gen.sv
module pbus_ads_gen (
  input  logic clk,
  input  logic rst,
  input  logic issue,
  input  logic take,
  output logic ads
);

  logic lag_q;
  logic ads_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lag_q <= 1'b0;
      ads_q <= 1'b0;
    end else begin
      lag_q <= take;
      ads_q <= issue | lag_q;
    end
  end

  assign ads = ads_q;

  p_ads_issue_r2: assert property (@(posedge clk) disable iff (rst)
    issue |=> ads);
  p_ads_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    ads |=> !ads);
  p_ads_lag_r4: assert property (@(posedge clk) disable iff (rst)
    take |=> ##1 ads);

endmodule

// File: rtl/pbus_cycle_trk.sv
module pbus_cycle_trk #(
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              issue,
  input  logic              take,
  input  logic              ads,
  input  logic              data_rdy,
  input  logic              addr_hold,
  input  logic [2:0]        req_kind,
  input  logic              req_lock,
  input  logic [BEAT_W-1:0] req_beats,
  output logic              act,
  output logic              idle,
  output logic              win,
  output logic              cur_hold_old,
  output logic              pipe_v,
  output logic              last_beat,
  output logic              promote,
  output logic [2:0]        cur_kind,
  output logic              cur_lock
);

  localparam logic [BEAT_W-1:0] LAST_REM = '0;

  logic              act_q, win_q, hold_old_q;
  logic [2:0]        kind_q;
  logic              lock_q;
  logic [BEAT_W-1:0] rem_q;
  logic              pipe_q, pseen_q, phold_q, plock_q;
  logic [2:0]        pkind_q;
  logic [BEAT_W-1:0] pbeats_q;

  assign last_beat = act_q && data_rdy && (rem_q == LAST_REM);
  assign promote   = last_beat && pipe_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q      <= 1'b0;
      win_q      <= 1'b0;
      hold_old_q <= 1'b0;
      kind_q     <= 3'd0;
      lock_q     <= 1'b0;
      rem_q      <= '0;
      pipe_q     <= 1'b0;
      pseen_q    <= 1'b0;
      phold_q    <= 1'b0;
      plock_q    <= 1'b0;
      pkind_q    <= 3'd0;
      pbeats_q   <= '0;
    end else begin
      // Strobe of the current cycle seen: window opens next clock.
      if (ads && !pipe_q) begin
        win_q      <= 1'b1;
        hold_old_q <= addr_hold;
      end
      // Strobe of the waiting cycle seen before it became current.
      if (ads && pipe_q) begin
        pseen_q <= 1'b1;
        phold_q <= addr_hold;
      end
      if (act_q && data_rdy) begin
        win_q <= 1'b0;
        rem_q <= rem_q - 1'b1;
      end
      if (take) begin
        pipe_q   <= 1'b1;
        pkind_q  <= req_kind;
        plock_q  <= req_lock;
        pbeats_q <= req_beats;
        pseen_q  <= 1'b0;
      end
      if (issue) begin
        act_q  <= 1'b1;
        kind_q <= req_kind;
        lock_q <= req_lock;
        rem_q  <= req_beats;
        win_q  <= 1'b0;
      end else if (last_beat) begin
        if (pipe_q) begin
          kind_q     <= pkind_q;
          lock_q     <= plock_q;
          rem_q      <= pbeats_q;
          pipe_q     <= 1'b0;
          win_q      <= pseen_q | ads;
          hold_old_q <= pseen_q ? phold_q : addr_hold;
        end else begin
          act_q <= 1'b0;
          win_q <= 1'b0;
        end
      end
    end
  end

  assign act          = act_q;
  assign idle         = !act_q && !pipe_q;
  assign win          = win_q;
  assign cur_hold_old = hold_old_q;
  assign pipe_v       = pipe_q;
  assign cur_kind     = kind_q;
  assign cur_lock     = lock_q;

  p_one_pipe_r10: assert property (@(posedge clk) disable iff (rst)
    pipe_v |-> !take);
  p_win_in_cycle_r3: assert property (@(posedge clk) disable iff (rst)
    win |-> act);
  p_promote_busy_r12: assert property (@(posedge clk) disable iff (rst)
    promote |=> act && !pipe_v);

endmodule

// File: rtl/pbus_attr_cap.sv
module pbus_attr_cap (
  input  logic clk,
  input  logic rst,
  input  logic new_cyc,
  input  logic act,
  input  logic na_smp,
  input  logic data_rdy,
  input  logic cache_en_in,
  input  logic wb_mode_in,
  output logic attr_valid,
  output logic attr_cacheable,
  output logic attr_wb
);

  logic done_q, ken_q, wb_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      done_q <= 1'b0;
      ken_q  <= 1'b0;
      wb_q   <= 1'b0;
    end else if (new_cyc) begin
      done_q <= 1'b0;
    end else if (act && !done_q && (na_smp || data_rdy)) begin
      done_q <= 1'b1;
      ken_q  <= cache_en_in;
      wb_q   <= wb_mode_in;
    end
  end

  assign attr_valid     = done_q;
  assign attr_cacheable = ken_q;
  assign attr_wb        = wb_q;

  p_attr_keep_r11: assert property (@(posedge clk) disable iff (rst)
    attr_valid && !new_cyc |=> attr_valid && $stable(attr_cacheable) && $stable(attr_wb));

endmodule

// File: rtl/pbus_na_seq.sv
module pbus_na_seq #(
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [2:0]        req_kind,
  input  logic              req_lock,
  input  logic [BEAT_W-1:0] req_beats,
  input  logic              nxt_addr,
  input  logic              data_rdy,
  input  logic              backoff,
  input  logic              hold_ack,
  input  logic              addr_hold,
  input  logic              init,
  input  logic              probe_rdy,
  input  logic              quiesce,
  input  logic              cache_en_in,
  input  logic              wb_mode_in,
  output logic              ads,
  output logic              cyc_busy,
  output logic              attr_valid,
  output logic              attr_cacheable,
  output logic              attr_wb
);
  import pbus_pkg::*;

  logic       act, idle, win, cur_hold_old, pipe_v, last_beat, promote, cur_lock;
  logic [2:0] cur_kind;
  logic       na_block, na_smp, take, issue;

  assign na_block = backoff | hold_ack | init | probe_rdy | quiesce;

  assign na_smp = !rst && win && nxt_addr && na_kind_ok(cur_kind, cur_lock)
                  && !na_block && (!addr_hold || !cur_hold_old);

  assign take = na_smp && !pipe_v && req_valid
                && pipe_kind_ok(req_kind, req_lock) && !last_beat;

  assign issue = !rst && idle && req_valid && !backoff && !hold_ack
                 && !addr_hold && !init && !quiesce;

  assign req_ready = issue | take;
  assign cyc_busy  = act;

  pbus_cycle_trk #(.BEAT_W(BEAT_W)) u_trk (
    .clk(clk), .rst(rst), .issue(issue), .take(take), .ads(ads),
    .data_rdy(data_rdy), .addr_hold(addr_hold), .req_kind(req_kind),
    .req_lock(req_lock), .req_beats(req_beats), .act(act), .idle(idle),
    .win(win), .cur_hold_old(cur_hold_old), .pipe_v(pipe_v),
    .last_beat(last_beat), .promote(promote), .cur_kind(cur_kind),
    .cur_lock(cur_lock)
  );

  pbus_ads_gen u_ads (
    .clk(clk), .rst(rst), .issue(issue), .take(take), .ads(ads)
  );

  pbus_attr_cap u_attr (
    .clk(clk), .rst(rst), .new_cyc(issue | promote), .act(act),
    .na_smp(na_smp), .data_rdy(data_rdy), .cache_en_in(cache_en_in),
    .wb_mode_in(wb_mode_in), .attr_valid(attr_valid),
    .attr_cacheable(attr_cacheable), .attr_wb(attr_wb)
  );

  p_ready_needs_valid_r9: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> req_valid);
  p_blocked_busy_r7: assert property (@(posedge clk) disable iff (rst)
    na_block && !idle |-> !req_ready);
  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> !ads && !cyc_busy && !attr_valid);

endmodule

// File: tb/tb_pbus_na_seq.sv
`timescale 1ns/1ps
module tb_pbus_na_seq;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst, req_valid, req_ready, req_lock, nxt_addr, data_rdy;
  logic backoff, hold_ack, addr_hold, init, probe_rdy, quiesce;
  logic cache_en_in, wb_mode_in, ads, cyc_busy, attr_valid, attr_cacheable, attr_wb;
  logic [2:0] req_kind;
  logic [1:0] req_beats;

  int n_chk = 0;
  int n_bad = 0;

  pbus_na_seq #(.BEAT_W(2)) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_lock(req_lock), .req_beats(req_beats),
    .nxt_addr(nxt_addr), .data_rdy(data_rdy), .backoff(backoff),
    .hold_ack(hold_ack), .addr_hold(addr_hold), .init(init),
    .probe_rdy(probe_rdy), .quiesce(quiesce), .cache_en_in(cache_en_in),
    .wb_mode_in(wb_mode_in), .ads(ads), .cyc_busy(cyc_busy),
    .attr_valid(attr_valid), .attr_cacheable(attr_cacheable), .attr_wb(attr_wb)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic quiet();
    req_valid = 0; req_kind = 0; req_lock = 0; req_beats = 0;
    nxt_addr = 0; data_rdy = 0; backoff = 0; hold_ack = 0; addr_hold = 0;
    init = 0; probe_rdy = 0; quiesce = 0; cache_en_in = 0; wb_mode_in = 0;
  endtask

  task automatic set_block(input int b, input logic v);
    case (b)
      1: backoff = v;
      2: hold_ack = v;
      3: init = v;
      4: probe_rdy = v;
      5: quiesce = v;
      6: addr_hold = v;
      default: ;
    endcase
  endtask

  task automatic start(input logic [2:0] k, input logic lk, input logic [1:0] b);
    req_kind = k; req_lock = lk; req_beats = b; req_valid = 1;
    #1 chk("R2 idle accept", req_ready, 1);
    tick();
    req_valid = 0;
    chk("R2 strobe after accept", ads, 1);
    tick();
    chk("R2 strobe one clock", ads, 0);
  endtask

  task automatic drain(output int cnt);
    cnt = 0;
    data_rdy = 1;
    for (int i = 0; i < 16; i++) begin
      tick();
      cnt++;
      if (!cyc_busy) break;
    end
    data_rdy = 0;
  endtask

  task automatic na_trial(input string tag, input logic [2:0] k, input logic lk,
                          input logic [2:0] pk, input logic plk, input logic pv,
                          input int blk, input int exp);
    int c;
    start(k, lk, 2'd1);
    req_kind = pk; req_lock = plk; req_beats = 0; req_valid = pv; nxt_addr = 1;
    set_block(blk, 1'b1);
    #1 chk({tag, " ready"}, req_ready, exp);
    tick();
    req_valid = 0; nxt_addr = 0; set_block(blk, 1'b0);
    chk({tag, " no early strobe"}, ads, 0);
    tick();
    chk({tag, " strobe two clocks later"}, ads, exp);
    drain(c);
    chk({tag, " R12 beats"}, c, (exp != 0) ? 3 : 2);
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL R1 watchdog: actual 0 expected 1");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int c;
    quiet();
    rst = 1;
    req_valid = 1;
    #1 chk("R1 no accept in reset", req_ready, 0);
    tick(); tick();
    chk("R1 ads", ads, 0);
    chk("R1 busy", cyc_busy, 0);
    chk("R1 attr_valid", attr_valid, 0);
    req_valid = 0;
    rst = 0;
    tick();

    // R1: reset drops a cycle in flight
    start(3'd0, 1'b0, 2'd3);
    rst = 1; tick(); rst = 0;
    chk("R1 cycle dropped", cyc_busy, 0);
    tick();

    // R2: holds keep an idle request off (probe_rdy does not)
    for (int b = 1; b <= 6; b++) begin
      req_kind = 0; req_valid = 1;
      set_block(b, 1'b1);
      #1 chk("R2 hold at idle", req_ready, (b == 4) ? 1 : 0);
      set_block(b, 1'b0);
      req_valid = 0;
      #1;
    end
    tick();

    // R5 / R6: current cycle type and lock sweep
    for (int k = 0; k < 7; k++)
      for (int lk = 0; lk < 2; lk++)
        na_trial((lk != 0) ? "R6 locked current" : "R5 kind",
                 3'(k), 1'(lk), 3'd0, 1'b0, 1'b1, 0,
                 (k < 2 && lk == 0) ? 1 : 0);

    // R7 / R8: holds during the window
    for (int b = 1; b <= 5; b++)
      na_trial("R7 hold ignores NA", 3'd0, 1'b0, 3'd0, 1'b0, 1'b1, b, 0);
    na_trial("R8 hold after start", 3'd1, 1'b0, 3'd0, 1'b0, 1'b1, 6, 1);

    // R9: pending request qualification
    na_trial("R9 writeback pending", 3'd0, 1'b0, 3'd2, 1'b0, 1'b1, 0, 0);
    na_trial("R9 locked pending", 3'd0, 1'b0, 3'd0, 1'b1, 1'b1, 0, 0);
    na_trial("R9 io pending", 3'd0, 1'b0, 3'd4, 1'b0, 1'b1, 0, 1);
    na_trial("R9 nothing pending", 3'd0, 1'b0, 3'd0, 1'b0, 1'b0, 0, 0);

    // R3: NA in the clock right after the strobe
    req_kind = 0; req_beats = 1; req_valid = 1;
    tick();
    req_beats = 0; nxt_addr = 1;
    #1 chk("R3 strobe clock", req_ready, 0);
    tick();
    nxt_addr = 0; req_valid = 0;
    tick();
    chk("R3 no strobe", ads, 0);
    drain(c);
    chk("R3 beats", c, 2);

    // R3: NA after the first data-ready
    start(3'd0, 1'b0, 2'd2);
    data_rdy = 1; tick(); data_rdy = 0;
    nxt_addr = 1; req_valid = 1; req_kind = 0; req_beats = 0;
    #1 chk("R3 after first beat", req_ready, 0);
    nxt_addr = 0; req_valid = 0;
    drain(c);
    chk("R3 remaining beats", c, 2);

    // R3: NA together with the first data-ready counts
    start(3'd0, 1'b0, 2'd1);
    data_rdy = 1; nxt_addr = 1; req_valid = 1; req_kind = 0; req_beats = 0;
    #1 chk("R3 with first beat", req_ready, 1);
    tick();
    data_rdy = 0; nxt_addr = 0; req_valid = 0;
    tick();
    chk("R4 strobe after NA", ads, 1);
    drain(c);
    chk("R12 promoted beats", c, 2);

    // R10: NA on the final data-ready
    start(3'd0, 1'b0, 2'd0);
    data_rdy = 1; nxt_addr = 1; req_valid = 1; req_kind = 0;
    #1 chk("R10 final beat", req_ready, 0);
    tick();
    data_rdy = 0; nxt_addr = 0; req_valid = 0;
    tick();
    chk("R10 no strobe", ads, 0);
    chk("R10 idle", cyc_busy, 0);

    // R10: second NA while one cycle waits
    start(3'd0, 1'b0, 2'd1);
    nxt_addr = 1; req_valid = 1; req_kind = 0; req_beats = 0;
    tick();
    #1 chk("R10 second NA", req_ready, 0);
    nxt_addr = 0; req_valid = 0;
    tick();
    chk("R4 strobe", ads, 1);
    drain(c);
    chk("R12 beats", c, 3);

    // R8: pipelined strobe seen under addr_hold
    start(3'd0, 1'b0, 2'd1);
    nxt_addr = 1; req_valid = 1; req_kind = 0; req_beats = 1;
    tick();
    nxt_addr = 0; req_valid = 0; addr_hold = 1;
    tick(); tick();
    data_rdy = 1; tick(); tick(); data_rdy = 0;
    chk("R12 promoted busy", cyc_busy, 1);
    nxt_addr = 1; req_valid = 1; req_beats = 0;
    #1 chk("R8 strobe under hold", req_ready, 0);
    addr_hold = 0;
    #1 chk("R8 hold released", req_ready, 1);
    nxt_addr = 0; req_valid = 0;
    drain(c);
    chk("R12 promoted cycle beats", c, 2);

    // R11: NA first, all attribute values
    for (int v = 0; v < 4; v++) begin
      start(3'd0, 1'b0, 2'd1);
      cache_en_in = v[0]; wb_mode_in = v[1]; nxt_addr = 1;
      tick();
      nxt_addr = 0;
      chk("R11 valid on NA", attr_valid, 1);
      chk("R11 ken on NA", attr_cacheable, v & 1);
      chk("R11 wb on NA", attr_wb, (v >> 1) & 1);
      cache_en_in = ~v[0]; wb_mode_in = ~v[1]; data_rdy = 1;
      tick();
      chk("R11 ken kept", attr_cacheable, v & 1);
      chk("R11 wb kept", attr_wb, (v >> 1) & 1);
      drain(c);
    end

    // R11: data-ready first
    start(3'd0, 1'b0, 2'd1);
    cache_en_in = 0; wb_mode_in = 1; data_rdy = 1;
    tick();
    chk("R11 valid on beat", attr_valid, 1);
    chk("R11 ken on beat", attr_cacheable, 0);
    chk("R11 wb on beat", attr_wb, 1);
    data_rdy = 0; cache_en_in = 1; wb_mode_in = 0; nxt_addr = 1;
    tick();
    nxt_addr = 0;
    chk("R11 ken not recaptured", attr_cacheable, 0);
    chk("R11 wb not recaptured", attr_wb, 1);
    drain(c);

    // R11: NA on an I/O cycle does not capture
    start(3'd3, 1'b0, 2'd1);
    cache_en_in = 1; nxt_addr = 1;
    tick();
    nxt_addr = 0;
    chk("R11 ignored NA no capture", attr_valid, 0);
    cache_en_in = 0; data_rdy = 1;
    tick();
    chk("R11 beat captures", attr_valid, 1);
    chk("R11 beat value", attr_cacheable, 0);
    drain(c);

    tick();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule